// File: doc/BRIEF.md
# Configurable Serial Character Transmitter

This block takes characters from a small queue and sends each one as an asynchronous serial frame on a single output line. The frame begins with one low start bit. The data bits follow, least significant bit first. An optional parity bit comes next, and the frame ends with a high stop period. A six-bit mode word chooses the frame format. The block takes the mode word in at the moment a character leaves the queue, so a frame already in flight keeps its own format. All bit timing counts pulses of an oversampling enable. An external divider supplies these pulses, sixteen of them per bit time by default.

A host writes characters through a valid/data pair and watches the ready, empty and done outputs. Three single-cycle commands are available. The first starts a line break, which holds the line low. The second ends the break. The third flushes the queue, aborts the current frame and ends any break. When the loopback control is set, the frame appears on a separate internal loop output and the external line rests high.

Top module: `sertx_core`

## Requirements
- R1: After reset, tx_line and loop_line are high, tx_ready and tx_empty are 1, and tx_done is 0.
- R2: A frame holds the line low for OVS ticks as the start bit. It then sends 5+k data bits, least significant bit first, each lasting OVS ticks, where k is mode_word[5:4].
- R3: mode_word[1:0] selects the parity bit that follows the data: 0 sends none, 1 makes the count of ones in data and parity odd, 2 makes it even, and 3 always sends 0.
- R4: mode_word[3:2] selects the stop period in ticks: 0 gives 9, 1 gives 16, 2 gives 25 and 3 gives 32 (default OVS of 16). tx_empty rises exactly when the last stop tick completes.
- R5: tx_done is a one-cycle pulse when a frame's stop period ends with the queue empty. It stays 0 when another character is waiting.
- R6: tx_ready goes low when DEPTH characters are queued. A write while full is dropped.
- R7: tx_empty is 1 only while the queue is empty and no frame is in progress.
- R8: cmd_brk_start drives tx_line low two cycles later and keeps it low through oscillator ticks. No queued character starts until cmd_brk_stop; after that, the queued characters go out in order.
- R9: With loop_en at 1, the frame appears on loop_line and tx_line stays high. With loop_en at 0, loop_line stays high.
- R10: cmd_tx_reset empties the queue, aborts any frame and ends any break. Two cycles later tx_line is high and tx_empty and tx_ready are 1.
- R11: A change of mode_word during a frame does not change that frame's length or format.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| os_tick | input | 1 | Oversampling enable pulse, OVS per bit time |
| mode_word | input | 6 | [1:0] parity, [3:2] stop period, [5:4] character size |
| loop_en | input | 1 | Route frames to loop_line and hold tx_line high |
| wr_valid | input | 1 | Write a character into the queue |
| wr_data | input | 8 | Character to write |
| cmd_brk_start | input | 1 | Start a line break |
| cmd_brk_stop | input | 1 | End a line break |
| cmd_tx_reset | input | 1 | Flush queue, abort frame, end break |
| tx_line | output | 1 | Serial output line |
| loop_line | output | 1 | Internal loopback copy of the frame |
| tx_ready | output | 1 | Queue has room |
| tx_empty | output | 1 | Queue empty and no frame in progress |
| tx_done | output | 1 | Pulse at the end of the last queued frame |

## Verification
The bench builds the block with OVS of 16 and DEPTH of 4. With OVS at 16, the 9/16 and 1+9/16 stop periods come out as whole tick counts (9 and 25), and the bench checks them to the exact tick. With a four-deep queue, the full condition and the dropped fifth write take only a few writes to reach. The break is held while the queue is filled, and the queued characters then leave back to back, which shows that tx_done stays low between frames.

// File: rtl/sertx_pkg.sv
// Shared types and helpers for the serial transmitter.
// Assumes the mode word bit layout: [1:0] parity, [3:2] stop, [5:4] size.
package sertx_pkg;

    localparam int unsigned CHAR_W = 8;

    typedef enum logic [1:0] {
        PAR_NONE  = 2'd0,
        PAR_ODD   = 2'd1,
        PAR_EVEN  = 2'd2,
        PAR_SPACE = 2'd3
    } par_sel_e;

    typedef struct packed {
        logic [1:0] size;
        logic [1:0] stop;
        par_sel_e   par;
    } mode_t;

    typedef enum logic [2:0] {
        FR_IDLE,
        FR_START,
        FR_DATA,
        FR_PAR,
        FR_STOP
    } fr_state_e;

    // Stop period in oversampling ticks for a given stop code.
    function automatic int unsigned stop_ticks(input logic [1:0] code, input int unsigned ovs);
        int unsigned frac;
        frac = (9 * ovs) / 16;
        case (code)
            2'd0:    return frac;
            2'd1:    return ovs;
            2'd2:    return ovs + frac;
            default: return 2 * ovs;
        endcase
    endfunction

endpackage

// File: rtl/sertx_fifo.sv
// Character queue for the transmitter.
// Drops writes while full, flush has priority over push and pop.
module sertx_fifo #(
    parameter int unsigned W     = 8,
    parameter int unsigned DEPTH = 4
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         push_i,
    input  logic [W-1:0] din_i,
    input  logic         pop_i,
    input  logic         flush_i,
    output logic [W-1:0] dout_o,
    output logic         full_o,
    output logic         empty_o
);
    localparam int unsigned AW = (DEPTH > 1) ? $clog2(DEPTH) : 1;
    localparam int unsigned CW = $clog2(DEPTH + 1);

    logic [W-1:0]  mem [DEPTH];
    logic [AW-1:0] wr_ptr, rd_ptr;
    logic [CW-1:0] count;
    logic          push_ok, pop_ok;

    assign full_o  = (count == CW'(DEPTH));
    assign empty_o = (count == '0);
    assign push_ok = push_i && !full_o && !flush_i;
    assign pop_ok  = pop_i && !empty_o && !flush_i;
    assign dout_o  = mem[rd_ptr];

    function automatic logic [AW-1:0] nxt(input logic [AW-1:0] p);
        return (p == AW'(DEPTH - 1)) ? '0 : p + 1'b1;
    endfunction

    // Storage write.
    always_ff @(posedge clk) begin
        if (push_ok) mem[wr_ptr] <= din_i;
    end

    // Pointer and occupancy tracking.
    always_ff @(posedge clk) begin
        if (!rst_n || flush_i) begin
            wr_ptr <= '0;
            rd_ptr <= '0;
            count  <= '0;
        end else begin
            if (push_ok) wr_ptr <= nxt(wr_ptr);
            if (pop_ok)  rd_ptr <= nxt(rd_ptr);
            case ({push_ok, pop_ok})
                2'b10:   count <= count + 1'b1;
                2'b01:   count <= count - 1'b1;
                default: count <= count;
            endcase
        end
    end

    assert_drop_when_full_R6: assert property (@(posedge clk) disable iff (!rst_n)
        (full_o && push_i && !pop_i && !flush_i) |=> (full_o && count == $past(count)));

    assert_flush_empties_R10: assert property (@(posedge clk) disable iff (!rst_n)
        flush_i |=> empty_o);

endmodule

// File: rtl/sertx_framer.sv
// Frame sequencer: start bit, data LSB first, optional parity, stop period.
// Assumes one character is loaded per frame. Bit time is OVS ticks.
// The format is latched at load.
module sertx_framer
    import sertx_pkg::*;
#(
    parameter int unsigned OVS = 16
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              tick_i,
    input  logic [5:0]        mode_i,
    input  logic              hold_i,
    input  logic              abort_i,
    input  logic              avail_i,
    input  logic [CHAR_W-1:0] data_i,
    output logic              pop_o,
    output logic              ser_o,
    output logic              busy_o,
    output logic              done_o
);
    localparam int unsigned CNT_W = $clog2(2 * OVS + 1);

    fr_state_e         state;
    mode_t             cfg, mode_in;
    logic [CNT_W-1:0]  cnt, lim;
    logic [2:0]        bidx;
    logic [CHAR_W-1:0] shreg, mask_in;
    logic              par_bit, ones_in, bit_end, last_data;

    assign mode_in   = mode_t'(mode_i);
    assign mask_in   = 8'hFF >> (2'd3 - mode_in.size);
    assign ones_in   = ^(data_i & mask_in);
    assign lim       = (state == FR_STOP) ? CNT_W'(stop_ticks(cfg.stop, OVS)) : CNT_W'(OVS);
    assign bit_end   = tick_i && (cnt == lim - 1'b1);
    assign last_data = (bidx == 3'd4 + {1'b0, cfg.size});
    assign pop_o     = (state == FR_IDLE) && avail_i && !hold_i && !abort_i;
    assign busy_o    = (state != FR_IDLE);

    // Line level driven by the current frame position.
    always_comb begin
        case (state)
            FR_START: ser_o = 1'b0;
            FR_DATA:  ser_o = shreg[0];
            FR_PAR:   ser_o = par_bit;
            default:  ser_o = 1'b1;
        endcase
    end

    // Frame sequencing and tick counting.
    always_ff @(posedge clk) begin
        if (!rst_n || abort_i) begin
            state   <= FR_IDLE;
            cnt     <= '0;
            bidx    <= '0;
            shreg   <= '0;
            par_bit <= 1'b0;
            cfg     <= '0;
            done_o  <= 1'b0;
        end else begin
            done_o <= 1'b0;
            if (state == FR_IDLE) begin
                if (pop_o) begin
                    cfg   <= mode_in;
                    shreg <= data_i;
                    case (mode_in.par)
                        PAR_ODD:  par_bit <= ~ones_in;
                        PAR_EVEN: par_bit <= ones_in;
                        default:  par_bit <= 1'b0;
                    endcase
                    cnt   <= '0;
                    bidx  <= '0;
                    state <= FR_START;
                end
            end else if (tick_i) begin
                if (!bit_end) begin
                    cnt <= cnt + 1'b1;
                end else begin
                    cnt <= '0;
                    case (state)
                        FR_START: state <= FR_DATA;
                        FR_DATA: begin
                            shreg <= shreg >> 1;
                            bidx  <= bidx + 1'b1;
                            if (last_data)
                                state <= (cfg.par == PAR_NONE) ? FR_STOP : FR_PAR;
                        end
                        FR_PAR:  state <= FR_STOP;
                        default: begin
                            state  <= FR_IDLE;
                            done_o <= !avail_i;
                        end
                    endcase
                end
            end
        end
    end

    assert_done_at_idle_R5: assert property (@(posedge clk) disable iff (!rst_n)
        done_o |-> (state == FR_IDLE && !avail_i));

    assert_hold_blocks_start_R8: assert property (@(posedge clk) disable iff (!rst_n)
        (state == FR_IDLE && hold_i) |=> (state == FR_IDLE));

    assert_format_latched_R11: assert property (@(posedge clk) disable iff (!rst_n)
        (state == FR_DATA || state == FR_PAR || state == FR_STOP) |-> $stable(cfg));

endmodule

// File: rtl/sertx_line.sv
// Output stage: break hold, loopback steering and registered line drivers.
// Assumes the commands are single-cycle pulses. Flush ends a break.
module sertx_line (
    input  logic clk,
    input  logic rst_n,
    input  logic ser_i,
    input  logic brk_on_i,
    input  logic brk_off_i,
    input  logic flush_i,
    input  logic loop_en_i,
    output logic brk_o,
    output logic tx_o,
    output logic loop_o
);
    logic brk_q;

    assign brk_o = brk_q;

    // Break state from start/stop commands.
    always_ff @(posedge clk) begin
        if (!rst_n || flush_i) brk_q <= 1'b0;
        else if (brk_on_i)     brk_q <= 1'b1;
        else if (brk_off_i)    brk_q <= 1'b0;
    end

    // Registered line drivers, glitch free.
    always_ff @(posedge clk) begin
        if (!rst_n || flush_i) begin
            tx_o   <= 1'b1;
            loop_o <= 1'b1;
        end else begin
            tx_o   <= brk_q ? 1'b0 : (loop_en_i ? 1'b1 : ser_i);
            loop_o <= loop_en_i ? (brk_q ? 1'b0 : ser_i) : 1'b1;
        end
    end

    assert_break_low_R8: assert property (@(posedge clk) disable iff (!rst_n)
        (brk_on_i && !flush_i) |=> ##1 !tx_o);

    assert_flush_idle_R10: assert property (@(posedge clk) disable iff (!rst_n)
        flush_i |=> ##1 tx_o);

    assert_loop_quiet_R9: assert property (@(posedge clk) disable iff (!rst_n)
        (loop_en_i && !brk_q && !flush_i) |=> tx_o);

endmodule

// File: rtl/sertx_core.sv
// Configurable serial character transmitter top level.
// Connects queue, frame sequencer and output stage. The host keeps os_tick
// at OVS pulses per bit time.
module sertx_core
    import sertx_pkg::*;
#(
    parameter int unsigned OVS   = 16,
    parameter int unsigned DEPTH = 4
) (
    input  logic        clk,
    input  logic        rst_n,
    input  logic        os_tick,
    input  logic [5:0]  mode_word,
    input  logic        loop_en,
    input  logic        wr_valid,
    input  logic [7:0]  wr_data,
    input  logic        cmd_brk_start,
    input  logic        cmd_brk_stop,
    input  logic        cmd_tx_reset,
    output logic        tx_line,
    output logic        loop_line,
    output logic        tx_ready,
    output logic        tx_empty,
    output logic        tx_done
);
    logic [CHAR_W-1:0] q_data;
    logic q_full, q_empty, pop, ser, busy, brk;

    sertx_fifo #(.W(CHAR_W), .DEPTH(DEPTH)) u_fifo (
        .clk     (clk),
        .rst_n   (rst_n),
        .push_i  (wr_valid),
        .din_i   (wr_data),
        .pop_i   (pop),
        .flush_i (cmd_tx_reset),
        .dout_o  (q_data),
        .full_o  (q_full),
        .empty_o (q_empty)
    );

    sertx_framer #(.OVS(OVS)) u_framer (
        .clk     (clk),
        .rst_n   (rst_n),
        .tick_i  (os_tick),
        .mode_i  (mode_word),
        .hold_i  (brk),
        .abort_i (cmd_tx_reset),
        .avail_i (!q_empty),
        .data_i  (q_data),
        .pop_o   (pop),
        .ser_o   (ser),
        .busy_o  (busy),
        .done_o  (tx_done)
    );

    sertx_line u_line (
        .clk       (clk),
        .rst_n     (rst_n),
        .ser_i     (ser),
        .brk_on_i  (cmd_brk_start),
        .brk_off_i (cmd_brk_stop),
        .flush_i   (cmd_tx_reset),
        .loop_en_i (loop_en),
        .brk_o     (brk),
        .tx_o      (tx_line),
        .loop_o    (loop_line)
    );

    assign tx_ready = !q_full;
    assign tx_empty = q_empty && !busy;

    assert_empty_means_idle_R7: assert property (@(posedge clk) disable iff (!rst_n)
        tx_empty |-> tx_ready);

endmodule

// File: tb/test_sertx_core.sv
module test_sertx_core;
    logic clk = 0, rst_n = 0, os_tick = 0, loop_en = 0, wr_valid = 0;
    logic cmd_brk_start = 0, cmd_brk_stop = 0, cmd_tx_reset = 0;
    logic [5:0] mode_word = 6'h34;
    logic [7:0] wr_data = 0;
    logic tx_line, loop_line, tx_ready, tx_empty, tx_done;
    logic s_done, s_empty, s_line, s_loop;
    int checks = 0, errors = 0;

    always #5 clk = ~clk;

    sertx_core #(.OVS(16), .DEPTH(4)) i_sertx_core (
        .clk(clk), .rst_n(rst_n), .os_tick(os_tick), .mode_word(mode_word),
        .loop_en(loop_en), .wr_valid(wr_valid), .wr_data(wr_data),
        .cmd_brk_start(cmd_brk_start), .cmd_brk_stop(cmd_brk_stop),
        .cmd_tx_reset(cmd_tx_reset), .tx_line(tx_line), .loop_line(loop_line),
        .tx_ready(tx_ready), .tx_empty(tx_empty), .tx_done(tx_done)
    );

    task automatic chk(input bit ok, input string req, input int act, input int exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s actual %0d expected %0d", req, act, exp);
        end
    endtask

    task automatic do_tick;
        @(negedge clk) os_tick = 1;
        @(negedge clk) os_tick = 0;
        s_done = tx_done; s_empty = tx_empty;
        @(negedge clk);
        s_line = tx_line; s_loop = loop_line;
    endtask

    task automatic write_char(input logic [7:0] d);
        @(negedge clk) wr_valid = 1; wr_data = d;
        @(negedge clk) wr_valid = 0;
    endtask

    task automatic pulse(input int which);
        @(negedge clk);
        if (which == 0) cmd_brk_start = 1;
        else if (which == 1) cmd_brk_stop = 1;
        else cmd_tx_reset = 1;
        @(negedge clk) cmd_brk_start = 0; cmd_brk_stop = 0; cmd_tx_reset = 0;
    endtask

    // Runs one frame and checks every bit centre, the stop length and done.
    task automatic run_frame(input logic [7:0] d, input logic [5:0] m, input bit wr,
                             input bit last, input bit lb, input logic [5:0] m_after,
                             input string tag);
        int n, p, s, total;
        logic par;
        logic [7:0] mask;
        logic [11:0] bits;
        logic v;
        n = 5 + m[5:4];
        p = (m[1:0] != 0) ? 1 : 0;
        mask = 8'hFF >> (3 - m[5:4]);
        par = (m[1:0] == 1) ? ~^(d & mask) : (m[1:0] == 2) ? ^(d & mask) : 1'b0;
        case (m[3:2]) 0: s = 9; 1: s = 16; 2: s = 25; default: s = 32; endcase
        total = 16 * (1 + n + p) + s;
        bits = '1; bits[0] = 0;
        for (int i = 0; i < n; i++) bits[1 + i] = d[i];
        if (p) bits[1 + n] = par;
        mode_word = m;
        loop_en = lb;
        if (wr) write_char(d);
        repeat (3) @(negedge clk);
        v = lb ? loop_line : tx_line;
        chk(v == 0, {"R2 start ", tag}, v, 0);
        for (int t = 1; t <= total; t++) begin
            do_tick();
            if (t == 1) mode_word = m_after;
            v = lb ? s_loop : s_line;
            if (t % 16 == 8 && t < 16 * (1 + n + p)) begin
                chk(v == bits[t / 16], {"R2/R3 bit ", tag}, v, bits[t / 16]);
                if (lb) chk(s_line == 1, {"R9 tx quiet ", tag}, s_line, 1);
            end
            if (t == 8) chk(s_empty == 0, {"R7 busy ", tag}, s_empty, 0);
            if (t == 16 * (1 + n + p) + 4) chk(v == 1, {"R4 stop level ", tag}, v, 1);
            if (t == total - 1) chk(s_empty == 0, {"R4 stop len ", tag}, s_empty, 0);
        end
        chk(s_empty == last, {"R4 R11 end empty ", tag}, s_empty, last);
        chk(s_done == last, {"R5 done ", tag}, s_done, last);
        mode_word = m;
        loop_en = 0;
    endtask

    task automatic t_reset;
        chk(tx_line == 1, "R1 line", tx_line, 1);
        chk(loop_line == 1, "R1 loop", loop_line, 1);
        chk(tx_ready == 1, "R1 ready", tx_ready, 1);
        chk(tx_empty == 1, "R1 empty", tx_empty, 1);
        chk(tx_done == 0, "R1 done", tx_done, 0);
    endtask

    task automatic t_formats;
        run_frame(8'hA5, 6'h34, 1, 1, 0, 6'h34, "8N1");
        run_frame(8'h13, 6'h01, 1, 1, 0, 6'h01, "5O 9/16");
        run_frame(8'h2B, 6'h1A, 1, 1, 0, 6'h1A, "6E 1+9/16");
        run_frame(8'h7F, 6'h2F, 1, 1, 0, 6'h2F, "7S 2");
        run_frame(8'hC3, 6'h35, 1, 1, 0, 6'h35, "8O 1");
        run_frame(8'h00, 6'h36, 1, 1, 0, 6'h36, "8E zeros");
    endtask

    task automatic t_full_break;
        pulse(0);
        @(negedge clk);
        chk(tx_line == 0, "R8 break low", tx_line, 0);
        write_char(8'h11); write_char(8'h22); write_char(8'h33); write_char(8'h44);
        chk(tx_ready == 0, "R6 full", tx_ready, 0);
        write_char(8'h99);
        for (int k = 0; k < 40; k++) begin
            do_tick();
            if (k % 10 == 0) chk(s_line == 0, "R8 held low", s_line, 0);
        end
        chk(tx_ready == 0, "R8 no start while break", tx_ready, 0);
        pulse(1);
        run_frame(8'h11, 6'h34, 0, 0, 0, 6'h34, "q1");
        run_frame(8'h22, 6'h34, 0, 0, 0, 6'h34, "q2");
        run_frame(8'h33, 6'h34, 0, 0, 0, 6'h34, "q3");
        run_frame(8'h44, 6'h34, 0, 1, 0, 6'h34, "q4 R6 drop");
        repeat (4) @(negedge clk);
        chk(tx_line == 1, "R6 dropped char not sent", tx_line, 1);
    endtask

    task automatic t_loop;
        run_frame(8'h5C, 6'h35, 1, 1, 1, 6'h35, "R9 loop");
        repeat (2) @(negedge clk);
        chk(loop_line == 1, "R9 loop idle", loop_line, 1);
    endtask

    task automatic t_reset_tx;
        mode_word = 6'h34;
        write_char(8'hA5);
        write_char(8'h3C);
        repeat (3) @(negedge clk);
        for (int k = 0; k < 20; k++) do_tick();
        pulse(2);
        @(negedge clk);
        chk(tx_line == 1, "R10 line", tx_line, 1);
        chk(tx_empty == 1, "R10 empty", tx_empty, 1);
        chk(tx_ready == 1, "R10 ready", tx_ready, 1);
        for (int k = 0; k < 40; k++) do_tick();
        chk(s_line == 1, "R10 stays idle", s_line, 1);
        pulse(0);
        @(negedge clk);
        chk(tx_line == 0, "R10 break on", tx_line, 0);
        pulse(2);
        @(negedge clk);
        chk(tx_line == 1, "R10 break cleared", tx_line, 1);
    endtask

    task automatic t_latch;
        run_frame(8'h96, 6'h34, 1, 1, 0, 6'h00, "R11 latch");
    endtask

    initial begin
        #1_000_000;
        errors++;
        $display("FAIL watchdog expired");
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1;
        @(negedge clk);
        t_reset();
        t_formats();
        t_full_break();
        t_loop();
        t_reset_tx();
        t_latch();
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end
endmodule